// File: doc/BRIEF.md
# Dynamic Segment Slot Counter

This block tracks the slot number through the dynamic part of a communication cycle. A start pulse loads the first dynamic slot number, which is the slot that follows the last static slot. From then on the slot number moves forward by one on each minislot tick, but only while the bus is quiet.

When a frame appears on the bus, counting pauses. Counting picks up again only after the channel-idle detector reports idle, which happens once 11 consecutive high bits have been seen. If that idle report is late by more than a configured number of minislots, the counter stops for the rest of the segment. Slot numbers have a hard ceiling. Once the count steps past the ceiling it drops to zero and stays there until the segment ends.

A running minislot number is compared against a configured latest-transmit minislot. That comparison gates a transmit-permit output and raises a sticky violation flag when a transmission starts too late. When the segment ends, the block does two things:
- It issues a single strobe so the aggregated channel status can be updated.
- If a frame is still on the bus, it flags a transmission across the boundary and requests a halt.

Top module: `dyn_slot_counter`

## Requirements
- R1: After reset, `slot_id` is 0, and `tx_permit`, `ltv_flag`, `tab_flag`, `halt_req` and `acs_strobe` are all 0.
- R2: A `seg_start` pulse has the following effects on the next cycle:
  - `slot_id` takes the value of `first_id`.
  - The minislot number becomes 1.
  - `ltv_flag` and `tab_flag` are cleared.
- R3: Inside the segment, each `mslot_tick` raises `slot_id` by exactly one, provided all of the following hold: the bus is not busy, no idle wait is pending, and counting has not been stopped or wrapped.
- R4: While `bus_busy` is high, ticks do not change `slot_id`, and `tx_permit` is 0. After the frame ends, ticks still do not advance the count until `idle_det` has pulsed. The first tick after that pulse advances by one.
- R5: A tick taken at `slot_id` 2047 sets `slot_id` to 0. The count then stays at 0 on further ticks until the segment ends, and `tx_permit` stays 0 throughout.
- R6: After a frame, the idle window is measured in minislot ticks. If `idle_limit`+1 ticks pass with the bus quiet and no `idle_det`, counting stops for the rest of the segment: a later `idle_det` does not resume it, and `tx_permit` stays 0.
- R7: `acs_strobe` is a one-cycle pulse in the cycle after `seg_end` is seen inside the segment. It never pulses on minislot ticks, and a `seg_end` outside the segment produces no pulse.
- R8: `tx_permit` is 1 only when all of the following hold:
  - the block is inside the segment;
  - counting is neither stopped nor wrapped;
  - the bus is quiet with no idle wait pending;
  - the minislot number (1 at segment start, plus 1 per tick) is at most `latest_tx`.
- R9: A `tx_start` while the minislot number is greater than `latest_tx` sets `ltv_flag` in the next cycle. A `tx_start` at or below `latest_tx` does not set it. Once set, `ltv_flag` stays set until the next `seg_start`.
- R10: If `bus_busy` is high when `seg_end` arrives inside the segment, then in the next cycle `tab_flag` is set (sticky until `seg_start`) and `halt_req` pulses for one cycle. If the bus is quiet at `seg_end`, neither `tab_flag` nor `halt_req` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seg_start | input | 1 | Start-of-dynamic-segment pulse |
| seg_end | input | 1 | End-of-dynamic-segment pulse |
| first_id | input | 11 | First dynamic slot number (nonzero) |
| mslot_tick | input | 1 | Minislot tick pulse |
| bus_busy | input | 1 | A frame occupies the bus |
| idle_det | input | 1 | Channel idle recognised (pulse) |
| idle_limit | input | 4 | Allowed idle-wait length in minislots |
| latest_tx | input | 13 | Latest minislot at which transmission may start |
| tx_start | input | 1 | Local transmission begins (pulse) |
| slot_id | output | 11 | Current dynamic slot number |
| tx_permit | output | 1 | Transmission may start now |
| ltv_flag | output | 1 | Latest-transmit violation (sticky) |
| tab_flag | output | 1 | Transmission across segment boundary (sticky) |
| halt_req | output | 1 | One-cycle halt request |
| acs_strobe | output | 1 | One-cycle aggregated-status update strobe |

## Verification
The assertions rely on a few assumptions about the inputs:
- `first_id` is nonzero, so a zero slot number can only come from a wrap.
- `seg_start` and `seg_end` never fall in the same cycle.
- `idle_det` does not coincide with a minislot tick.

The bench drives every stimulus on the falling edge and keeps these pulses in separate cycles. It only loads nonzero first slot numbers, including 2045 to reach the ceiling.

// File: rtl/dyn_slot_counter.sv
module dyn_slot_counter #(
  parameter int ID_W   = 11,
  parameter int MS_W   = 13,
  parameter int IDLE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_start,
  input  logic              seg_end,
  input  logic [ID_W-1:0]   first_id,
  input  logic              mslot_tick,
  input  logic              bus_busy,
  input  logic              idle_det,
  input  logic [IDLE_W-1:0] idle_limit,
  input  logic [MS_W-1:0]   latest_tx,
  input  logic              tx_start,
  output logic [ID_W-1:0]   slot_id,
  output logic              tx_permit,
  output logic              ltv_flag,
  output logic              tab_flag,
  output logic              halt_req,
  output logic              acs_strobe
);
  localparam logic [ID_W-1:0] MAX_ID = {ID_W{1'b1}};
  localparam logic [MS_W-1:0] MS_TOP = {MS_W{1'b1}};

  logic              active, wrapped, frozen, wait_idle;
  logic [MS_W-1:0]   ms_num;
  logic [IDLE_W-1:0] idle_cnt;
  logic              advance;

  assign advance = active && mslot_tick && !bus_busy && !wait_idle && !frozen && !wrapped;

  assign tx_permit = active && !wrapped && !frozen && !wait_idle && !bus_busy &&
                     (ms_num <= latest_tx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      wrapped    <= 1'b0;
      frozen     <= 1'b0;
      wait_idle  <= 1'b0;
      ms_num     <= '0;
      idle_cnt   <= '0;
      slot_id    <= '0;
      ltv_flag   <= 1'b0;
      tab_flag   <= 1'b0;
      halt_req   <= 1'b0;
      acs_strobe <= 1'b0;
    end else begin
      acs_strobe <= 1'b0;
      halt_req   <= 1'b0;
      if (seg_start) begin
        active    <= 1'b1;
        slot_id   <= first_id;
        ms_num    <= {{(MS_W-1){1'b0}}, 1'b1};
        wrapped   <= 1'b0;
        frozen    <= 1'b0;
        wait_idle <= 1'b0;
        idle_cnt  <= '0;
        ltv_flag  <= 1'b0;
        tab_flag  <= 1'b0;
      end else if (active) begin
        if (seg_end) begin
          active     <= 1'b0;
          acs_strobe <= 1'b1;
          if (bus_busy) begin
            tab_flag <= 1'b1;
            halt_req <= 1'b1;
          end
        end else begin
          if (mslot_tick && ms_num != MS_TOP)
            ms_num <= ms_num + 1'b1;
          if (advance) begin
            if (slot_id == MAX_ID) begin
              slot_id <= '0;
              wrapped <= 1'b1;
            end else begin
              slot_id <= slot_id + 1'b1;
            end
          end
          if (bus_busy) begin
            wait_idle <= 1'b1;
            idle_cnt  <= '0;
          end else if (wait_idle) begin
            if (idle_det) begin
              wait_idle <= 1'b0;
              idle_cnt  <= '0;
            end else if (mslot_tick && !frozen) begin
              if (idle_cnt >= idle_limit) frozen <= 1'b1;
              else idle_cnt <= idle_cnt + 1'b1;
            end
          end
          if (tx_start && (ms_num > latest_tx))
            ltv_flag <= 1'b1;
        end
      end
    end
  end

  // R7
  acs_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acs_strobe |-> $past(seg_end));

  // R7
  acs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acs_strobe |=> !acs_strobe);

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && !seg_start) |=> $stable(slot_id));

  // R5
  wrap_no_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_permit |-> (slot_id != '0));

  // R9
  ltv_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ltv_flag && !seg_start) |=> ltv_flag);

  // R10
  halt_with_tab_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> tab_flag);

  // R10
  halt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> !halt_req);
endmodule

// File: tb/tb_dyn_slot_counter.sv
module tb_dyn_slot_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_start = 0, seg_end = 0, mslot_tick = 0, bus_busy = 0;
  logic        idle_det = 0, tx_start = 0;
  logic [10:0] first_id = 11'd10;
  logic [3:0]  idle_limit = 4'd4;
  logic [12:0] latest_tx = 13'd100;
  logic [10:0] slot_id;
  logic        tx_permit, ltv_flag, tab_flag, halt_req, acs_strobe;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dyn_slot_counter dut (
    .clk(clk), .rst_n(rst_n), .seg_start(seg_start), .seg_end(seg_end),
    .first_id(first_id), .mslot_tick(mslot_tick), .bus_busy(bus_busy),
    .idle_det(idle_det), .idle_limit(idle_limit), .latest_tx(latest_tx),
    .tx_start(tx_start), .slot_id(slot_id), .tx_permit(tx_permit),
    .ltv_flag(ltv_flag), .tab_flag(tab_flag), .halt_req(halt_req),
    .acs_strobe(acs_strobe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    mslot_tick = 1; @(negedge clk); mslot_tick = 0;
  endtask

  task automatic start(input int id);
    first_id = id[10:0];
    seg_start = 1; @(negedge clk); seg_start = 0;
  endtask

  task automatic finish_seg();
    seg_end = 1; @(negedge clk); seg_end = 0;
  endtask

  task automatic t_reset();
    chk("R1 slot_id", slot_id, 0);
    chk("R1 permit", tx_permit, 0);
    chk("R1 ltv", ltv_flag, 0);
    chk("R1 tab", tab_flag, 0);
    chk("R1 halt", halt_req, 0);
    chk("R1 acs", acs_strobe, 0);
  endtask

  task automatic t_basic();
    latest_tx = 13'd100;
    start(10);
    chk("R2 first id", slot_id, 10);
    chk("R8 permit at start", tx_permit, 1);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R3 advance", slot_id, 11 + i);
      chk("R7 no acs on tick", acs_strobe, 0);
    end
  endtask

  task automatic t_busy();
    idle_limit = 4'd4;
    bus_busy = 1;
    @(negedge clk);
    chk("R4 permit busy", tx_permit, 0);
    tick(); tick();
    chk("R4 hold busy", slot_id, 13);
    bus_busy = 0;
    @(negedge clk);
    chk("R4 permit waiting idle", tx_permit, 0);
    tick();
    chk("R4 hold until idle", slot_id, 13);
    idle_det = 1; @(negedge clk); idle_det = 0;
    chk("R8 permit after idle", tx_permit, 1);
    tick();
    chk("R4 resume", slot_id, 14);
  endtask

  task automatic t_end_strobe();
    finish_seg();
    chk("R7 acs pulse", acs_strobe, 1);
    chk("R10 tab quiet end", tab_flag, 0);
    chk("R10 halt quiet end", halt_req, 0);
    @(negedge clk);
    chk("R7 acs single", acs_strobe, 0);
    finish_seg();
    chk("R7 outside segment", acs_strobe, 0);
    @(negedge clk);
    chk("R7 outside segment later", acs_strobe, 0);
  endtask

  task automatic t_idle_timeout();
    idle_limit = 4'd2;
    start(20);
    bus_busy = 1; tick(); bus_busy = 0;
    chk("R4 hold", slot_id, 20);
    tick(); tick();
    idle_det = 1; @(negedge clk); idle_det = 0;
    tick();
    chk("R6 late idle still counts", slot_id, 21);
    bus_busy = 1; tick(); bus_busy = 0;
    tick(); tick(); tick();
    idle_det = 1; @(negedge clk); idle_det = 0;
    tick(); tick();
    chk("R6 stopped", slot_id, 21);
    chk("R6 permit low", tx_permit, 0);
    finish_seg();
  endtask

  task automatic t_wrap();
    latest_tx = 13'd100;
    start(2045);
    tick(); chk("R3 2046", slot_id, 2046);
    tick(); chk("R3 2047", slot_id, 2047);
    tick(); chk("R5 wrap to 0", slot_id, 0);
    chk("R5 permit low", tx_permit, 0);
    tick(); tick();
    chk("R5 held 0", slot_id, 0);
    chk("R5 permit still low", tx_permit, 0);
    finish_seg();
    chk("R7 acs after wrap", acs_strobe, 1);
    chk("R5 held at end", slot_id, 0);
  endtask

  task automatic t_latest();
    latest_tx = 13'd3;
    start(5);
    tick();
    tx_start = 1; @(negedge clk); tx_start = 0;
    chk("R9 no violation at 2", ltv_flag, 0);
    tick();
    chk("R8 permit at 3", tx_permit, 1);
    tick();
    chk("R8 permit past latest", tx_permit, 0);
    tx_start = 1; @(negedge clk); tx_start = 0;
    chk("R9 violation", ltv_flag, 1);
    tick(); tick();
    chk("R9 sticky", ltv_flag, 1);
    finish_seg();
    start(5);
    chk("R2 ltv cleared", ltv_flag, 0);
  endtask

  task automatic t_boundary();
    latest_tx = 13'd100;
    bus_busy = 1; @(negedge clk);
    finish_seg();
    chk("R10 tab set", tab_flag, 1);
    chk("R10 halt pulse", halt_req, 1);
    chk("R7 acs with tab", acs_strobe, 1);
    @(negedge clk);
    chk("R10 halt single", halt_req, 0);
    chk("R10 tab sticky", tab_flag, 1);
    bus_busy = 0;
    start(7);
    chk("R2 tab cleared", tab_flag, 0);
    chk("R2 reload id", slot_id, 7);
    finish_seg();
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_busy();
    t_end_strobe();
    t_idle_timeout();
    t_wrap();
    t_latest();
    t_boundary();
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule